// File: doc/BRIEF.md
# Tiled Weight and Partial-Sum Sequencer

This controller lets a small physical grid of bit-serial synapse operators (the patch, `PR` rows by `PC` columns) stand in for a much larger `N`×`N` weight matrix. It visits every patch position in turn. Row blocks advance inside a column group, and column groups follow one another. At each position it streams the matching weights from a synchronous weight RAM into the grid, one word per cycle, and then holds a compute strobe for a fixed number of cycles. It then merges each column's new contribution into a running total kept in a separate partial-sum RAM.

A single `start` pulse sequences the whole matrix and `done` marks the end. Where `N` is not a multiple of the patch size, the patch hangs over the matrix edge. Slots outside the matrix are loaded with zero and never read from RAM, and their columns are never written. The first row block of each column group takes zero as the previous total, so the partial-sum RAM needs no clearing beforehand. The synapse arithmetic and the activation stage sit outside this block.

Top module: `patch_seq`

## Requirements
- R1: After reset, and while idle, `done`, `wt_rd_en`, `arr_ld_valid`, `arr_comp`, `ps_rd_en` and `ps_wr_en` are all 0. A `start` pulse received while a sequence is running has no effect: no second sequence and no second `done`.
- R2: Patch positions are visited with the row block index rb (rows rb·PR…) advancing first through ceil(N/PR) blocks, then the column group index cg (columns cg·PC…) advancing through ceil(N/PC) groups.
- R3: Within a position, weights are loaded in slot order: row 0 columns 0..PC-1, then row 1, and so on, one per cycle. Each load presents patch-local `arr_ld_row`/`arr_ld_col` and the weight RAM word at address grow·N+gcol, where grow = rb·PR+row and gcol = cg·PC+col. The RAM returns data one cycle after the read is issued.
- R4: A slot with grow ≥ N or gcol ≥ N is loaded with data 0 and issues no weight RAM read, so a full sequence makes exactly N·N weight reads.
- R5: After the last load of a position, `arr_comp` is high for exactly `COMP_CYC` consecutive cycles, with no load, weight read or partial-sum write in those cycles.
- R6: After compute, for every in-range column gcol of the position, the partial-sum RAM at address gcol is written with the previous total plus column c of `arr_result`. Column c occupies bits [c·SW +: SW]. After a full sequence, entry gcol holds the sum of the whole matrix column gcol, modulo 2^SW.
- R7: In the first row block (rb = 0) no partial-sum read is issued and the previous total is taken as 0. In later blocks each write follows its read by one cycle to the same address.
- R8: `done` is high for exactly one cycle. It becomes visible L = P·(PR·PC + COMP_CYC + PC + 3) clock edges after the edge that samples `start`, where P = ceil(N/PR)·ceil(N/PC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a full sequence when idle |
| done | output | 1 | One-cycle end-of-sequence pulse |
| wt_rd_en | output | 1 | Weight RAM read enable |
| wt_rd_addr | output | clog2(N·N) | Weight RAM address, row·N+col |
| wt_rd_data | input | WW | Weight RAM data, one cycle after the read |
| arr_ld_valid | output | 1 | Weight load strobe to the patch |
| arr_ld_row | output | clog2(PR) | Patch-local row of the loaded weight |
| arr_ld_col | output | clog2(PC) | Patch-local column of the loaded weight |
| arr_ld_data | output | WW | Weight to load (0 outside the matrix) |
| arr_comp | output | 1 | Compute strobe to the patch |
| arr_result | input | PC·SW | Per-column patch results, column c at [c·SW +: SW] |
| ps_rd_en | output | 1 | Partial-sum RAM read enable |
| ps_rd_addr | output | clog2(N) | Partial-sum read address (global column) |
| ps_rd_data | input | SW | Partial-sum read data, one cycle after the read |
| ps_wr_en | output | 1 | Partial-sum RAM write enable |
| ps_wr_addr | output | clog2(N) | Partial-sum write address |
| ps_wr_data | output | SW | New partial sum |

## Verification
The embedded properties check several things on every cycle. Every weight read is followed by a load, and clipped loads carry zero. All addresses stay inside their RAMs. Each partial-sum read is paired with a write to the same column one cycle later. The compute strobe never overlaps loads or writes and always follows a load, and `done` never lasts two cycles. Only the bench scenarios can show the rest: the exact visiting order of positions and slots against the matrix, the final column totals, read counts that prove clipping and first-block bypass, and the absolute latency. They also show that a stray `start` mid-run changes nothing.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMP,
    ST_ACC,
    ST_ADV,
    ST_DONE
  } seq_state_e;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // global row/column to row-major flat index
  function automatic int flat_index(int row, int col, int n);
    return row * n + col;
  endfunction

  // global index of a patch-local coordinate
  function automatic int global_pos(int block, int size, int local_idx);
    return block * size + local_idx;
  endfunction

endpackage

// File: rtl/pseq_load.sv
module pseq_load
  import pseq_pkg::*;
#(
  parameter int N   = 256,
  parameter int PR  = 6,
  parameter int PC  = 18,
  parameter int WW  = 8,
  parameter int RBW = 6,
  parameter int CGW = 4,
  localparam int RB  = ceil_div(N, PR),
  localparam int CG  = ceil_div(N, PC),
  localparam int WAW = $clog2(N * N),
  localparam int RW  = $clog2(PR),
  localparam int CW  = $clog2(PC),
  localparam int GW  = $clog2(((RB * PR > CG * PC) ? RB * PR : CG * PC) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [RBW-1:0] rb,
  input  logic [CGW-1:0] cg,
  output logic           wt_rd_en,
  output logic [WAW-1:0] wt_rd_addr,
  input  logic [WW-1:0]  wt_rd_data,
  output logic           ld_valid,
  output logic [RW-1:0]  ld_row,
  output logic [CW-1:0]  ld_col,
  output logic [WW-1:0]  ld_data
);

  logic [RW-1:0] r_cnt;
  logic [CW-1:0] c_cnt;
  logic [GW-1:0] grow, gcol;
  logic          slot_live;
  logic          live_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !issue) begin
      r_cnt <= '0;
      c_cnt <= '0;
    end else if (c_cnt == CW'(PC - 1)) begin
      c_cnt <= '0;
      r_cnt <= r_cnt + 1'b1;
    end else begin
      c_cnt <= c_cnt + 1'b1;
    end
  end

  assign grow      = GW'(global_pos(int'(rb), PR, int'(r_cnt)));
  assign gcol      = GW'(global_pos(int'(cg), PC, int'(c_cnt)));
  assign slot_live = (grow < GW'(N)) && (gcol < GW'(N));

  assign wt_rd_en   = issue && slot_live;
  assign wt_rd_addr = WAW'(flat_index(int'(grow), int'(gcol), N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      live_q   <= 1'b0;
      ld_row   <= '0;
      ld_col   <= '0;
    end else begin
      ld_valid <= issue;
      live_q   <= issue && slot_live;
      ld_row   <= r_cnt;
      ld_col   <= c_cnt;
    end
  end

  assign ld_data = (ld_valid && live_q) ? wt_rd_data : '0;

  AST_WT_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wt_rd_en |-> (int'(wt_rd_addr) < N * N)); // R4
  AST_READ_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wt_rd_en |=> ld_valid); // R3
  AST_CLIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !$past(wt_rd_en)) |-> (ld_data == '0)); // R4

endmodule

// File: rtl/pseq_acc.sv
module pseq_acc
  import pseq_pkg::*;
#(
  parameter int N   = 256,
  parameter int PC  = 18,
  parameter int SW  = 16,
  parameter int CGW = 4,
  localparam int CG  = ceil_div(N, PC),
  localparam int NAW = $clog2(N),
  localparam int CW  = $clog2(PC),
  localparam int GW  = $clog2(CG * PC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic           first_blk,
  input  logic [CGW-1:0] cg,
  input  logic [PC*SW-1:0] arr_result,
  output logic           ps_rd_en,
  output logic [NAW-1:0] ps_rd_addr,
  input  logic [SW-1:0]  ps_rd_data,
  output logic           ps_wr_en,
  output logic [NAW-1:0] ps_wr_addr,
  output logic [SW-1:0]  ps_wr_data
);

  logic [CW-1:0]  c_cnt;
  logic [GW-1:0]  gcol;
  logic           col_live;
  logic           use_prev_q;
  logic [CW-1:0]  col_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !issue) c_cnt <= '0;
    else                  c_cnt <= c_cnt + 1'b1;
  end

  assign gcol       = GW'(global_pos(int'(cg), PC, int'(c_cnt)));
  assign col_live   = gcol < GW'(N);
  assign ps_rd_en   = issue && col_live && !first_blk;
  assign ps_rd_addr = NAW'(gcol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_wr_en   <= 1'b0;
      use_prev_q <= 1'b0;
      col_q      <= '0;
      ps_wr_addr <= '0;
    end else begin
      ps_wr_en   <= issue && col_live;
      use_prev_q <= !first_blk;
      col_q      <= c_cnt;
      ps_wr_addr <= NAW'(gcol);
    end
  end

  assign ps_wr_data = (use_prev_q ? ps_rd_data : '0) + arr_result[int'(col_q)*SW +: SW];

  AST_RD_WR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ps_rd_en |=> (ps_wr_en && ps_wr_addr == $past(ps_rd_addr))); // R7
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_wr_en |-> (int'(ps_wr_addr) < N)); // R6

endmodule

// File: rtl/patch_seq.sv
module patch_seq
  import pseq_pkg::*;
#(
  parameter int N        = 256,
  parameter int PR       = 6,
  parameter int PC       = 18,
  parameter int WW       = 8,
  parameter int SW       = 16,
  parameter int COMP_CYC = 24,
  localparam int WAW = $clog2(N * N),
  localparam int NAW = $clog2(N),
  localparam int RW  = $clog2(PR),
  localparam int CW  = $clog2(PC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             wt_rd_en,
  output logic [WAW-1:0]   wt_rd_addr,
  input  logic [WW-1:0]    wt_rd_data,
  output logic             arr_ld_valid,
  output logic [RW-1:0]    arr_ld_row,
  output logic [CW-1:0]    arr_ld_col,
  output logic [WW-1:0]    arr_ld_data,
  output logic             arr_comp,
  input  logic [PC*SW-1:0] arr_result,
  output logic             ps_rd_en,
  output logic [NAW-1:0]   ps_rd_addr,
  input  logic [SW-1:0]    ps_rd_data,
  output logic             ps_wr_en,
  output logic [NAW-1:0]   ps_wr_addr,
  output logic [SW-1:0]    ps_wr_data
);

  localparam int RB   = ceil_div(N, PR);
  localparam int CG   = ceil_div(N, PC);
  localparam int TOT  = PR * PC;
  localparam int RBW  = $clog2(RB + 1);
  localparam int CGW  = $clog2(CG + 1);
  localparam int CNTW = $clog2(max3(TOT, COMP_CYC, PC) + 1);

  seq_state_e      st;
  logic [CNTW-1:0] cnt;
  logic [RBW-1:0]  rb;
  logic [CGW-1:0]  cg;

  logic ld_issue, acc_issue, load_end, comp_end, acc_end, last_blk, last_patch;

  assign ld_issue   = (st == ST_LOAD) && (cnt < CNTW'(TOT));
  assign acc_issue  = (st == ST_ACC) && (cnt < CNTW'(PC));
  assign load_end   = (st == ST_LOAD) && (cnt == CNTW'(TOT));
  assign comp_end   = (st == ST_COMP) && (cnt == CNTW'(COMP_CYC - 1));
  assign acc_end    = (st == ST_ACC) && (cnt == CNTW'(PC));
  assign last_blk   = (rb == RBW'(RB - 1));
  assign last_patch = last_blk && (cg == CGW'(CG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      rb  <= '0;
      cg  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_LOAD;
          cnt <= '0;
          rb  <= '0;
          cg  <= '0;
        end
        ST_LOAD: if (load_end) begin
          st <= ST_COMP; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_COMP: if (comp_end) begin
          st <= ST_ACC; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_ACC: if (acc_end) begin
          st <= ST_ADV; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_ADV: begin
          st <= last_patch ? ST_DONE : ST_LOAD;
          if (last_blk) begin
            rb <= '0;
            cg <= cg + 1'b1;
          end else begin
            rb <= rb + 1'b1;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done     = (st == ST_DONE);
  assign arr_comp = (st == ST_COMP);

  pseq_load #(.N(N), .PR(PR), .PC(PC), .WW(WW), .RBW(RBW), .CGW(CGW)) load_i (
    .clk(clk), .rst_n(rst_n), .issue(ld_issue), .rb(rb), .cg(cg),
    .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr), .wt_rd_data(wt_rd_data),
    .ld_valid(arr_ld_valid), .ld_row(arr_ld_row), .ld_col(arr_ld_col),
    .ld_data(arr_ld_data)
  );

  pseq_acc #(.N(N), .PC(PC), .SW(SW), .CGW(CGW)) acc_i (
    .clk(clk), .rst_n(rst_n), .issue(acc_issue), .first_blk(rb == '0), .cg(cg),
    .arr_result(arr_result),
    .ps_rd_en(ps_rd_en), .ps_rd_addr(ps_rd_addr), .ps_rd_data(ps_rd_data),
    .ps_wr_en(ps_wr_en), .ps_wr_addr(ps_wr_addr), .ps_wr_data(ps_wr_data)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_COMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    arr_comp |-> (!arr_ld_valid && !wt_rd_en && !ps_wr_en)); // R5
  AST_COMP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_comp) |-> $past(arr_ld_valid)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!wt_rd_en && !ps_rd_en && !arr_comp)); // R1

endmodule

// File: tb/patch_seq_tb_top.sv
module patch_seq_tb_top;
  localparam int N = 10, PR = 3, PC = 4, WW = 8, SW = 16, COMP_CYC = 3;
  localparam int RB = (N + PR - 1) / PR, CG = (N + PC - 1) / PC;
  localparam int P = RB * CG, TOT = PR * PC;
  localparam int LAT = P * (TOT + COMP_CYC + PC + 3);
  localparam int WAW = $clog2(N * N), NAW = $clog2(N), RW = $clog2(PR), CW = $clog2(PC);
  localparam int NRUN = 4;
  // stimulus table: weight seed, stray start mid-run, expected done latency
  localparam int RUN_SEED [NRUN] = '{3, 77, 140, 201};
  localparam bit RUN_POKE [NRUN] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int RUN_LAT  [NRUN] = '{LAT, LAT, LAT, LAT};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, wt_rd_en, arr_ld_valid, arr_comp, ps_rd_en, ps_wr_en;
  logic [WAW-1:0] wt_rd_addr;
  logic [WW-1:0] wt_rd_data, arr_ld_data;
  logic [RW-1:0] arr_ld_row;
  logic [CW-1:0] arr_ld_col;
  logic [PC*SW-1:0] arr_result;
  logic [NAW-1:0] ps_rd_addr, ps_wr_addr;
  logic [SW-1:0] ps_rd_data, ps_wr_data;

  always #5 clk = ~clk;

  patch_seq #(.N(N), .PR(PR), .PC(PC), .WW(WW), .SW(SW), .COMP_CYC(COMP_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr), .wt_rd_data(wt_rd_data),
    .arr_ld_valid(arr_ld_valid), .arr_ld_row(arr_ld_row), .arr_ld_col(arr_ld_col),
    .arr_ld_data(arr_ld_data), .arr_comp(arr_comp), .arr_result(arr_result),
    .ps_rd_en(ps_rd_en), .ps_rd_addr(ps_rd_addr), .ps_rd_data(ps_rd_data),
    .ps_wr_en(ps_wr_en), .ps_wr_addr(ps_wr_addr), .ps_wr_data(ps_wr_data)
  );

  int n_chk = 0, n_fail = 0;
  int cur_seed = 0;
  logic fill_req = 1'b0;

  function automatic logic [WW-1:0] wfun(int a, int s);
    return WW'(a * 37 + s * 11 + (a >> 2));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // weight RAM model, one-cycle read
  always @(posedge clk) if (wt_rd_en) wt_rd_data <= wfun(int'(wt_rd_addr), cur_seed);

  // partial-sum RAM model
  logic [SW-1:0] ps_mem [N];
  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < N; i++) ps_mem[i] <= 16'hBEEF;
    end else if (ps_wr_en) ps_mem[ps_wr_addr] <= ps_wr_data;
    if (ps_rd_en) ps_rd_data <= ps_mem[ps_rd_addr];
  end

  // patch model: per-column sum of loaded weights
  logic [WW-1:0] patch [PR][PC];
  always_comb begin
    for (int c = 0; c < PC; c++) begin
      logic [SW-1:0] s;
      s = '0;
      for (int r = 0; r < PR; r++) s = s + SW'(patch[r][c]);
      arr_result[c*SW +: SW] = s;
    end
  end

  // monitor: independent walk of the expected slot/position order
  int m_slot = 0, m_rb = 0, m_cg = 0;
  int n_ld = 0, n_ord_err = 0, n_dat_err = 0, n_clip_err = 0, n_comp_err = 0;
  int n_wrd = 0, n_psr = 0, n_psw = 0, n_comp = 0, n_done = 0, n_wide = 0;
  logic prev_done = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (arr_ld_valid) begin
      int r, c, gr, gc;
      r = m_slot / PC; c = m_slot % PC;
      gr = m_rb * PR + r; gc = m_cg * PC + c;
      n_ld++;
      if (int'(arr_ld_row) != r || int'(arr_ld_col) != c) n_ord_err++;
      if (gr < N && gc < N) begin
        if (arr_ld_data != wfun(gr * N + gc, cur_seed)) n_dat_err++;
      end else if (arr_ld_data != '0) n_clip_err++;
      patch[arr_ld_row][arr_ld_col] = arr_ld_data;
      m_slot++;
      if (m_slot == TOT) begin
        m_slot = 0; m_rb++;
        if (m_rb == RB) begin m_rb = 0; m_cg = (m_cg + 1) % CG; end
      end
    end
    if (arr_comp) begin
      n_comp++;
      if (m_slot != 0) n_comp_err++;
    end
    if (wt_rd_en) n_wrd++;
    if (ps_rd_en) n_psr++;
    if (ps_wr_en) n_psw++;
    if (done) n_done++;
    if (done && prev_done) n_wide++;
    prev_done = done;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < PR; r++) for (int c = 0; c < PC; c++) patch[r][c] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !wt_rd_en && !arr_ld_valid && !arr_comp && !ps_rd_en && !ps_wr_en,
        "R1", "outputs quiet in reset", 0, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(n_ld == 0 && n_wrd == 0 && n_done == 0 && !arr_comp, "R1", "idle without start", n_ld + n_wrd, 0);

    for (int run = 0; run < NRUN; run++) begin
      int s_ld, s_wrd, s_psr, s_psw, s_comp, s_done, s_ord, s_dat, s_clip, s_cerr, lat;
      s_ld = n_ld; s_wrd = n_wrd; s_psr = n_psr; s_psw = n_psw; s_comp = n_comp;
      s_done = n_done; s_ord = n_ord_err; s_dat = n_dat_err; s_clip = n_clip_err; s_cerr = n_comp_err;
      cur_seed = RUN_SEED[run];
      fill_req = 1'b1; @(negedge clk); fill_req = 1'b0;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      lat = 0;
      while (1) begin
        @(posedge clk); lat++;
        @(negedge clk);
        start = (RUN_POKE[run] && lat == 50);
        if (done || lat > 4000) break;
      end
      start = 1'b0;
      chk(lat == RUN_LAT[run], "R8", "done latency", lat, RUN_LAT[run]);
      repeat (40) @(negedge clk);
      chk(n_done - s_done == 1, "R8", "single done (R1 stray start ignored)", n_done - s_done, 1);
      chk(n_wide == 0, "R8", "done width one cycle", n_wide, 0);
      chk(n_ld - s_ld == P * TOT, "R1", "load count, no restart", n_ld - s_ld, P * TOT);
      chk(n_ord_err == s_ord, "R3", "patch-local row/col order", n_ord_err - s_ord, 0);
      chk(n_dat_err == s_dat, "R2", "weight data follows position order (R3)", n_dat_err - s_dat, 0);
      chk(n_clip_err == s_clip, "R4", "clipped slots load zero", n_clip_err - s_clip, 0);
      chk(n_wrd - s_wrd == N * N, "R4", "weight reads only in range", n_wrd - s_wrd, N * N);
      chk(n_comp - s_comp == P * COMP_CYC, "R5", "compute cycles", n_comp - s_comp, P * COMP_CYC);
      chk(n_comp_err == s_cerr, "R5", "compute only after full load", n_comp_err - s_cerr, 0);
      chk(n_psr - s_psr == (RB - 1) * N, "R7", "no partial-sum read in first block", n_psr - s_psr, (RB - 1) * N);
      chk(n_psw - s_psw == RB * N, "R6", "partial-sum writes", n_psw - s_psw, RB * N);
      for (int gc = 0; gc < N; gc++) begin
        logic [SW-1:0] e;
        e = '0;
        for (int gr = 0; gr < N; gr++) e = e + SW'(wfun(gr * N + gc, cur_seed));
        chk(ps_mem[gc] == e, "R6", $sformatf("column total %0d", gc), ps_mem[gc], e);
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule